// File: doc/BRIEF.md
# Processor Debug and Run Control Port

This block sits between a host register bus and a small embedded processor. The host uses it to hold the processor in reset, to freeze it with a stall, and to stop it when it fetches from a chosen address. The host can also pick one of the processor's internal registers and read its value. It also sets the 32-bit base address from which the processor fetches code. That address is written as two 16-bit halves, and the block takes those writes only while the processor is held in reset.

The reset output also feeds the processor's timers and its cache, so one control bit restarts the whole subsystem. When the host releases that bit, the processor starts again from its boot address. The processor's watchdog can also pulse the reset output. A control bit lets the host block that path, so the host can debug without the watchdog restarting the core.

Host reads are registered. Read data appears one cycle after the read strobe and stays until the next read. Writes take effect at the clock edge that samples the write strobe.

Top module: `proc_dbg_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the control word (address 0) reads 0x001, `core_rst` is 1, `core_stall` is 0, and the breakpoint, select and base registers are 0.
- R2: Control bit 0 drives `core_rst`. The output follows the bit one clock after the register updates.
- R3: While control bit 1 is 1, `core_stall` is 1, one clock after the register updates.
- R4: When control bit 2 is 1, a fetch with `fetch_vld`=1 and `fetch_addr` equal to the breakpoint register (address 1) sets control bit 3 at that edge. When bit 2 is 0, or the address differs, bit 3 is not set.
- R5: Control bit 3 is sticky, and while it is 1 `core_stall` is 1. Writing 1 to bit 3 clears it. Writing 0 to bit 3 leaves it unchanged.
- R6: If a breakpoint match and a write of 1 to bit 3 land on the same edge, the match wins and bit 3 stays 1.
- R7: The select register (address 2, SEL_W bits) drives `core_sel`. A read of address 3 returns `core_reg_val`.
- R8: The base-address halves are written at address 4 (low) and address 5 (high), and `code_base` = {high, low}. A write to either half while control bit 0 is 0 is ignored.
- R9: A `wdt_evt` pulse drives `core_rst` to 1 on the next clock when control bit 9 is 0. When bit 9 is 1, the pulse has no effect.
- R10: Read data is valid one clock after `host_rd`. Unmapped addresses read 0. Control bits other than 0, 1, 2, 3 and 9 read 0.
- R11: No breakpoint match is taken while control bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW (3) | Host register address |
| host_wdata | input | DW (32) | Host write data |
| host_rdata | output | DW (32) | Registered read data |
| fetch_vld | input | 1 | Processor fetch address valid |
| fetch_addr | input | PC_W (16) | Processor fetch address |
| core_reg_val | input | DW (32) | Value of the selected processor register |
| wdt_evt | input | 1 | Watchdog reset request pulse |
| core_rst | output | 1 | Processor, timer and cache reset |
| core_stall | output | 1 | Processor stall |
| core_sel | output | SEL_W (5) | Processor register select |
| code_base | output | 2*HALF_W (32) | Code base address |

## Verification
The hardest case to reach from the ports is a breakpoint match that lands on the same edge as the host's write-one clear of the hit flag. The stimulus places the matching fetch and the clear write in the same clock period, then reads the flag back. The two gating cases need similar set-up. A match is tried while the reset bit holds the core, and base writes are tried after the reset bit is released. In both cases the host reads back or observes the output the stimulus could have disturbed.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_BP      = 1;
  localparam int unsigned A_SEL     = 2;
  localparam int unsigned A_OUT     = 3;
  localparam int unsigned A_BASE_LO = 4;
  localparam int unsigned A_BASE_HI = 5;

  localparam int unsigned CB_RST   = 0;
  localparam int unsigned CB_STALL = 1;
  localparam int unsigned CB_BPEN  = 2;
  localparam int unsigned CB_HIT   = 3;
  localparam int unsigned CB_WDM   = 9;

  typedef struct packed {
    logic wdm;
    logic bpen;
    logic stall;
    logic rst;
  } ctrl_t;
endpackage

// File: rtl/pdc_regs.sv
module pdc_regs
  import pdc_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 3,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [AW-1:0]       host_addr,
  input  logic [DW-1:0]       host_wdata,
  output logic [DW-1:0]       host_rdata,
  input  logic                hit,
  input  logic [DW-1:0]       core_reg_val,
  output ctrl_t               ctrl,
  output logic                hit_clr,
  output logic [PC_W-1:0]     bp_addr,
  output logic [SEL_W-1:0]    sel,
  output logic [2*HALF_W-1:0] base
);
  localparam int unsigned NHALF = 2;

  logic wr_ctrl, wr_bp, wr_sel;
  assign wr_ctrl = host_wr && (host_addr == AW'(A_CTRL));
  assign wr_bp   = host_wr && (host_addr == AW'(A_BP));
  assign wr_sel  = host_wr && (host_addr == AW'(A_SEL));
  assign hit_clr = wr_ctrl && host_wdata[CB_HIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '{wdm: 1'b0, bpen: 1'b0, stall: 1'b0, rst: 1'b1};
      bp_addr <= '0;
      sel     <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.rst   <= host_wdata[CB_RST];
        ctrl.stall <= host_wdata[CB_STALL];
        ctrl.bpen  <= host_wdata[CB_BPEN];
        ctrl.wdm   <= host_wdata[CB_WDM];
      end
      if (wr_bp)  bp_addr <= host_wdata[PC_W-1:0];
      if (wr_sel) sel     <= host_wdata[SEL_W-1:0];
    end
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic wr_half;
    assign wr_half = host_wr && ctrl.rst &&
                     (host_addr == AW'(A_BASE_LO + h));
    always_ff @(posedge clk) begin
      if (rst)          base[h*HALF_W +: HALF_W] <= '0;
      else if (wr_half) base[h*HALF_W +: HALF_W] <= host_wdata[HALF_W-1:0];
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (host_addr == AW'(A_CTRL)) begin
      rd_mux[CB_RST]   = ctrl.rst;
      rd_mux[CB_STALL] = ctrl.stall;
      rd_mux[CB_BPEN]  = ctrl.bpen;
      rd_mux[CB_HIT]   = hit;
      rd_mux[CB_WDM]   = ctrl.wdm;
    end else if (host_addr == AW'(A_BP)) begin
      rd_mux[PC_W-1:0] = bp_addr;
    end else if (host_addr == AW'(A_SEL)) begin
      rd_mux[SEL_W-1:0] = sel;
    end else if (host_addr == AW'(A_OUT)) begin
      rd_mux = core_reg_val;
    end else if (host_addr == AW'(A_BASE_LO)) begin
      rd_mux[HALF_W-1:0] = base[HALF_W-1:0];
    end else if (host_addr == AW'(A_BASE_HI)) begin
      rd_mux[HALF_W-1:0] = base[2*HALF_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  // R8
  base_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.rst |=> $stable(base));
endmodule

// File: rtl/pdc_bp_match.sv
module pdc_bp_match #(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bp_en,
  input  logic            core_held,
  input  logic            fetch_vld,
  input  logic [PC_W-1:0] fetch_addr,
  input  logic [PC_W-1:0] bp_addr,
  input  logic            hit_clr,
  output logic            hit
);
  logic match;
  assign match = bp_en && !core_held && fetch_vld && (fetch_addr == bp_addr);

  always_ff @(posedge clk) begin
    if (rst)          hit <= 1'b0;
    else if (match)   hit <= 1'b1;
    else if (hit_clr) hit <= 1'b0;
  end

  // R4
  hit_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> $past(bp_en && fetch_vld && (fetch_addr == bp_addr)));
  // R5
  hit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    hit && !hit_clr |=> hit);
endmodule

// File: rtl/pdc_ctl_out.sv
module pdc_ctl_out (
  input  logic clk,
  input  logic rst,
  input  logic rst_bit,
  input  logic stall_bit,
  input  logic hit,
  input  logic wdt_evt,
  input  logic wdt_mask,
  output logic core_rst,
  output logic core_stall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst   <= 1'b1;
      core_stall <= 1'b0;
    end else begin
      core_rst   <= rst_bit || (wdt_evt && !wdt_mask);
      core_stall <= stall_bit || hit;
    end
  end

  // R3
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_stall) |-> $past(stall_bit || hit));
  // R9
  wdt_masked_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_mask && !rst_bit |=> !core_rst);
endmodule

// File: rtl/proc_dbg_ctrl.sv
module proc_dbg_ctrl
  import pdc_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 3,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [AW-1:0]       host_addr,
  input  logic [DW-1:0]       host_wdata,
  output logic [DW-1:0]       host_rdata,
  input  logic                fetch_vld,
  input  logic [PC_W-1:0]     fetch_addr,
  input  logic [DW-1:0]       core_reg_val,
  input  logic                wdt_evt,
  output logic                core_rst,
  output logic                core_stall,
  output logic [SEL_W-1:0]    core_sel,
  output logic [2*HALF_W-1:0] code_base
);
  ctrl_t           ctrl;
  logic            hit, hit_clr;
  logic [PC_W-1:0] bp_addr;

  pdc_regs #(.DW(DW), .AW(AW), .PC_W(PC_W), .SEL_W(SEL_W), .HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .hit(hit), .core_reg_val(core_reg_val), .ctrl(ctrl), .hit_clr(hit_clr),
    .bp_addr(bp_addr), .sel(core_sel), .base(code_base)
  );

  pdc_bp_match #(.PC_W(PC_W)) u_bp (
    .clk(clk), .rst(rst), .bp_en(ctrl.bpen), .core_held(ctrl.rst),
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .bp_addr(bp_addr),
    .hit_clr(hit_clr), .hit(hit)
  );

  pdc_ctl_out u_out (
    .clk(clk), .rst(rst), .rst_bit(ctrl.rst), .stall_bit(ctrl.stall),
    .hit(hit), .wdt_evt(wdt_evt), .wdt_mask(ctrl.wdm),
    .core_rst(core_rst), .core_stall(core_stall)
  );

  // R11
  held_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.rst && !hit |=> !hit);
endmodule

// File: tb/proc_dbg_ctrl_tb.sv
module proc_dbg_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        fetch_vld = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [31:0] core_reg_val = '0;
  logic        wdt_evt = 1'b0;
  logic        core_rst, core_stall;
  logic [4:0]  core_sel;
  logic [31:0] code_base;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  proc_dbg_ctrl u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .core_reg_val(core_reg_val),
    .wdt_evt(wdt_evt), .core_rst(core_rst), .core_stall(core_stall),
    .core_sel(core_sel), .code_base(code_base)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 3'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = 3'(a);
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic fetch(input logic [15:0] a);
    @(negedge clk);
    fetch_vld = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_vld = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d);  check("R1 ctrl", d, 32'h1);
    check("R1 core_rst", 32'(core_rst), 32'h1);
    check("R1 core_stall", 32'(core_stall), 32'h0);
    rd(2, d);  check("R1 sel", d, 32'h0);
    check("R1 base", code_base, 32'h0);
  endtask

  task automatic t_base_and_release;
    wr(4, 32'h1234); wr(5, 32'hABCD);
    check("R8 base in reset", code_base, 32'hABCD1234);
    wr(0, 32'h0);
    @(negedge clk);
    check("R2 core_rst released", 32'(core_rst), 32'h0);
    wr(4, 32'h5555);
    check("R8 base write ignored", code_base, 32'hABCD1234);
  endtask

  task automatic t_stall;
    wr(0, 32'h2);
    @(negedge clk);
    check("R3 stall on", 32'(core_stall), 32'h1);
    repeat (3) @(negedge clk);
    check("R3 stall held", 32'(core_stall), 32'h1);
    wr(0, 32'h0);
    @(negedge clk);
    check("R3 stall off", 32'(core_stall), 32'h0);
  endtask

  task automatic t_breakpoint;
    logic [31:0] d;
    wr(1, 32'h0100);
    fetch(16'h0100);
    rd(0, d); check("R4 disabled no hit", d, 32'h0);
    wr(0, 32'h4);
    fetch(16'h00FF);
    rd(0, d); check("R4 mismatch no hit", d, 32'h4);
    fetch(16'h0100);
    rd(0, d); check("R4 hit set", d, 32'hC);
    check("R5 stall on hit", 32'(core_stall), 32'h1);
    wr(0, 32'h4);
    rd(0, d); check("R5 write 0 keeps hit", d, 32'hC);
    wr(0, 32'hC);
    rd(0, d); check("R5 w1c clears hit", d, 32'h4);
    check("R5 stall released", 32'(core_stall), 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    fetch(16'h0100);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 3'd0; host_wdata = 32'hC;
    fetch_vld = 1'b1; fetch_addr = 16'h0100;
    @(negedge clk);
    host_wr = 1'b0; fetch_vld = 1'b0;
    rd(0, d); check("R6 set beats clear", d, 32'hC);
    wr(0, 32'hC);
    rd(0, d); check("R6 cleared after", d, 32'h4);
  endtask

  task automatic t_held_gate;
    logic [31:0] d;
    wr(0, 32'h5);
    fetch(16'h0100);
    rd(0, d); check("R11 no hit in reset", d, 32'h5);
    wr(0, 32'h4);
  endtask

  task automatic t_select;
    logic [31:0] d;
    wr(2, 32'h13);
    check("R7 core_sel", 32'(core_sel), 32'h13);
    core_reg_val = 32'hDEADBEEF;
    rd(3, d); check("R7 readout", d, 32'hDEADBEEF);
    rd(7, d); check("R10 unmapped", d, 32'h0);
  endtask

  task automatic t_watchdog;
    logic [31:0] d;
    wr(0, 32'h0000_F3F0);
    rd(0, d); check("R10 ctrl mask", d, 32'h200);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk); wdt_evt = 1'b0;
    check("R9 masked", 32'(core_rst), 32'h0);
    wr(0, 32'h0);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk); wdt_evt = 1'b0;
    check("R9 wdt reset", 32'(core_rst), 32'h1);
    @(negedge clk);
    check("R9 wdt pulse ends", 32'(core_rst), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_base_and_release();
    t_stall();
    t_breakpoint();
    t_set_wins();
    t_held_gate();
    t_select();
    t_watchdog();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule